// File: doc/BRIEF.md
# Automatic RTS/CTS Hardware Flow Controller

This block handles hardware handshaking for a single serial channel. On the transmit side it decides, at each character boundary, whether the transmitter may begin the next character. It does this by looking at the clear-to-send input after passing it through a synchronizer. A character that has already started is never cut short, because the decision is taken only at a boundary.

On the receive side the block drives the request-to-send output from two things: how full the receive buffer is, and whether a character is being assembled at that moment. The request is withdrawn as soon as the first data bit of the character that will take the last free slot arrives. This gives the far end time to stop before the buffer overflows. The request is raised again only when there is room for the character that may still be in flight.

Automatic handshaking is active only when both the auto-flow enable and the RTS control bit are set. Otherwise RTS follows the control bit and the transmitter ignores CTS. The shift registers and the buffer belong to neighbouring blocks. This block sees only the buffer fill count and the receiver's strobes.

Top module: `auto_flow_ctrl`

## Requirements
- R1: While `rstN` is low, `rtsN` is 1 (inactive), and `txPermit` is 0 whenever `txBoundary` is 0.
- R2: Handshaking is active only when `autoFlowEn` and `rtsCtl` are both 1. Otherwise `rtsN` equals the inverse of `rtsCtl` as it was at the previous rising edge.
- R3: With handshaking inactive, `txPermit` equals `txBoundary`, whatever the value of `ctsN`.
- R4: `ctsN` passes through two flops. A change on it affects `txPermit` only after two rising edges.
- R5: With handshaking active, `txPermit` is 1 exactly when `txBoundary` is 1 and the synchronized `ctsN` is 0 (low means clear to send).
- R6: `txPermit` is never 1 without `txBoundary`. A CTS change between boundaries therefore cannot stop a character that has started, and the character ends with its stop bits.
- R7: With handshaking active and exactly one free slot (`fillCount` = DEPTH-1), a `rxBitStb` that is the first data bit of the current character (the first strobe since `rxBusy` rose) sets `rtsN` to 1 at the next edge.
- R8: Data-bit strobes after the first one in a character do not change `rtsN`.
- R9: With handshaking active and the buffer full (`fillCount` = DEPTH), `rtsN` is 1 from the next edge onward.
- R10: While deasserted, RTS is raised again (`rtsN` = 0 at the next edge) when at least one slot is free and `rxBusy` is 0.
- R11: RTS is raised (or kept raised) at the next edge whenever at least two slots are free, even while `rxBusy` is 1.
- R12: While deasserted, with exactly one free slot and `rxBusy` at 1, RTS stays deasserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctsN | input | 1 | Clear-to-send from the far end, active low, asynchronous |
| fillCount | input | CNT_W (5) | Receive buffer occupancy, 0 to DEPTH |
| rxBusy | input | 1 | Receiver is assembling a character |
| rxBitStb | input | 1 | One-cycle pulse per data bit received |
| txBoundary | input | 1 | Transmitter is at a character boundary and wants to start |
| autoFlowEn | input | 1 | Auto-flow enable control bit |
| rtsCtl | input | 1 | RTS control bit |
| rtsN | output | 1 | Request-to-send, active low, registered |
| txPermit | output | 1 | Start of the next character is allowed this cycle |

## Verification
Two events can fall on the same edge: the first data bit of a character arriving, and the buffer reader freeing a slot. When that happens, the drop rule and the raise rule compete. The bench provokes this by lowering the fill count from DEPTH-1 to DEPTH-2 in the same cycle as the first data-bit strobe. The expected result is that RTS stays asserted. The bench also raises a transmit boundary in that same cycle, so the permit path and the RTS path are judged together against the cycle-accurate reference model.

// File: rtl/afc_pkg.sv
package afc_pkg;
  typedef struct packed {
    logic ctsActive;
    logic firstBit;
    logic noneFree;
    logic oneFree;
    logic multiFree;
    logic rxIdle;
  } afcEvt_t;
endpackage

// File: rtl/afc_sense.sv
module afc_sense
  import afc_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctsN,
  input  logic [CNT_W-1:0] fillCount,
  input  logic             rxBusy,
  input  logic             rxBitStb,
  output afcEvt_t          evt
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] TWO_C   = CNT_W'(2);

  logic [SYNC_STAGES-1:0] ctsPipe;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) ctsPipe[i] <= 1'b1;
        else if (i == 0) ctsPipe[i] <= ctsN;
        else ctsPipe[i] <= ctsPipe[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  logic bitSeen;
  always_ff @(posedge clk) begin
    if (!rstN) bitSeen <= 1'b0;
    else if (!rxBusy) bitSeen <= 1'b0;
    else if (rxBitStb) bitSeen <= 1'b1;
  end

  logic [CNT_W-1:0] freeSlots;
  always_comb begin
    freeSlots     = DEPTH_C - fillCount;
    evt.ctsActive = ~ctsPipe[SYNC_STAGES-1];
    evt.firstBit  = rxBusy & rxBitStb & ~bitSeen;
    evt.noneFree  = (freeSlots == '0);
    evt.oneFree   = (freeSlots == CNT_W'(1));
    evt.multiFree = (freeSlots >= TWO_C);
    evt.rxIdle    = ~rxBusy;
  end

  // R8: a first-bit event never repeats within one character
  assert_first_once_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rxBusy && rxBitStb && bitSeen) |-> !evt.firstBit);
endmodule

// File: rtl/afc_decide.sv
module afc_decide
  import afc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  afcEvt_t evt,
  input  logic    autoFlowEn,
  input  logic    rtsCtl,
  input  logic    txBoundary,
  output logic    rtsN,
  output logic    txPermit
);
  logic flowOn;
  logic rtsOn;
  logic rtsNext;
  logic pastOk;

  assign flowOn = autoFlowEn & rtsCtl;

  always_comb begin
    if (!flowOn)    rtsNext = rtsCtl;
    else if (rtsOn) rtsNext = ~(evt.noneFree | (evt.firstBit & evt.oneFree));
    else            rtsNext = evt.multiFree | (evt.oneFree & evt.rxIdle);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtsOn  <= 1'b0;
      pastOk <= 1'b0;
    end else begin
      rtsOn  <= rtsNext;
      pastOk <= 1'b1;
    end
  end

  assign rtsN     = ~rtsOn;
  assign txPermit = txBoundary & (~flowOn | evt.ctsActive);

  assert_permit_at_boundary_R6: assert property (@(posedge clk) disable iff (!rstN)
    txPermit |-> txBoundary);

  assert_follow_ctl_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pastOk && !$past(autoFlowEn && rtsCtl)) |-> (rtsN == !$past(rtsCtl)));

  assert_full_drops_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flowOn && evt.noneFree) |=> rtsN);

  assert_room_raises_R11: assert property (@(posedge clk) disable iff (!rstN)
    (flowOn && evt.multiFree) |=> !rtsN);

  assert_last_slot_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    (flowOn && evt.firstBit && evt.oneFree) |=> rtsN);
endmodule

// File: rtl/auto_flow_ctrl.sv
module auto_flow_ctrl
  import afc_pkg::*;
#(
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctsN,
  input  logic [CNT_W-1:0] fillCount,
  input  logic             rxBusy,
  input  logic             rxBitStb,
  input  logic             txBoundary,
  input  logic             autoFlowEn,
  input  logic             rtsCtl,
  output logic             rtsN,
  output logic             txPermit
);
  afcEvt_t evt;

  afc_sense #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_sense (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .fillCount(fillCount),
    .rxBusy(rxBusy), .rxBitStb(rxBitStb), .evt(evt)
  );

  afc_decide u_decide (
    .clk(clk), .rstN(rstN), .evt(evt), .autoFlowEn(autoFlowEn),
    .rtsCtl(rtsCtl), .txBoundary(txBoundary), .rtsN(rtsN), .txPermit(txPermit)
  );
endmodule

// File: tb/auto_flow_ctrl_tb.sv
module auto_flow_ctrl_tb;
  localparam int DEPTH = 16;
  localparam int CW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctsN = 1'b1;
  logic [CW-1:0] fillCount = '0;
  logic rxBusy = 1'b0, rxBitStb = 1'b0, txBoundary = 1'b0;
  logic autoFlowEn = 1'b0, rtsCtl = 1'b0;
  logic rtsN, txPermit;

  int checks = 0, fails = 0;
  string phase = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  auto_flow_ctrl u_dut (
    .clk(clk), .rstN(rstN), .ctsN(ctsN), .fillCount(fillCount),
    .rxBusy(rxBusy), .rxBitStb(rxBitStb), .txBoundary(txBoundary),
    .autoFlowEn(autoFlowEn), .rtsCtl(rtsCtl), .rtsN(rtsN), .txPermit(txPermit)
  );

  // behavioural reference model
  bit mS0 = 1, mS1 = 1, mRts = 0;
  int bitCount = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mS0 = 1; mS1 = 1; mRts = 0; bitCount = 0;
    end else begin
      int freeNow;
      bit first, on;
      freeNow = DEPTH - int'(fillCount);
      first = rxBusy && rxBitStb && (bitCount == 0);
      on = autoFlowEn && rtsCtl;
      if (!on) mRts = rtsCtl;
      else if (mRts) mRts = !(freeNow == 0 || (first && freeNow == 1));
      else mRts = (freeNow >= 2) || (freeNow >= 1 && !rxBusy);
      bitCount = rxBusy ? bitCount + int'(rxBitStb) : 0;
      mS1 = mS0; mS0 = ctsN;
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rstN) begin
        check("R1", "rtsN in reset", rtsN, 1'b1);
        if (!txBoundary) check("R1", "txPermit in reset", txPermit, 1'b0);
      end else begin
        check(phase, "rtsN", rtsN, !mRts);
        check(phase, "txPermit", txPermit,
              txBoundary && (!(autoFlowEn && rtsCtl) || !mS1));
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  initial begin
    tick(4);
    rstN = 1'b1;
    // R2 / R3: manual mode
    phase = "R2"; rtsCtl = 1; tick(2); rtsCtl = 0; tick(2); rtsCtl = 1; tick(1);
    phase = "R3"; ctsN = 1; txBoundary = 1; tick(3);
    check("R3", "permit ignores CTS", txPermit, 1'b1);
    txBoundary = 0; rtsCtl = 0; autoFlowEn = 1; tick(2);
    phase = "R2"; tick(2);
    check("R2", "auto enable alone leaves RTS off", rtsN, 1'b1);
    rtsCtl = 1; tick(2);
    check("R2", "both bits set raises RTS", rtsN, 1'b0);
    // R5 / R4
    phase = "R5"; txBoundary = 1; tick(3);
    check("R5", "CTS inactive blocks start", txPermit, 1'b0);
    phase = "R4"; ctsN = 0; tick(1);
    check("R4", "one edge not enough", txPermit, 1'b0);
    tick(1);
    check("R4", "two edges pass CTS", txPermit, 1'b1);
    phase = "R5"; tick(3);
    ctsN = 1; tick(1); ctsN = 0; tick(3);
    // R6: CTS drops mid-character
    phase = "R6"; txBoundary = 0; ctsN = 1; tick(5);
    check("R6", "no permit between boundaries", txPermit, 1'b0);
    txBoundary = 1; tick(1);
    check("R6", "next boundary gated", txPermit, 1'b0);
    txBoundary = 0; ctsN = 0; tick(3);
    // R11: two free slots, a whole character
    phase = "R11"; fillCount = DEPTH - 2; rxBusy = 1; tick(2);
    repeat (8) begin rxBitStb = 1; tick(1); rxBitStb = 0; tick(1); end
    check("R11", "two free keeps RTS", rtsN, 1'b0);
    rxBusy = 0; fillCount = DEPTH - 1; tick(2);
    // R7 / R8: last slot character
    phase = "R7"; rxBusy = 1; tick(2);
    check("R7", "start bit alone keeps RTS", rtsN, 1'b0);
    rxBitStb = 1; tick(1); rxBitStb = 0;
    check("R7", "first data bit drops RTS", rtsN, 1'b1);
    phase = "R8";
    repeat (7) begin tick(1); rxBitStb = 1; tick(1); rxBitStb = 0; end
    check("R8", "later bits leave RTS off", rtsN, 1'b1);
    phase = "R9"; fillCount = DEPTH; rxBusy = 0; tick(3);
    check("R9", "full buffer keeps RTS off", rtsN, 1'b1);
    // R12 / R10
    phase = "R12"; rxBusy = 1; fillCount = DEPTH - 1; tick(3);
    check("R12", "one free while busy stays off", rtsN, 1'b1);
    phase = "R10"; rxBusy = 0; tick(2);
    check("R10", "one free idle raises", rtsN, 1'b0);
    // R9 with RTS on, then R11 raise while busy
    phase = "R9"; fillCount = DEPTH; tick(2);
    check("R9", "full drops RTS", rtsN, 1'b1);
    phase = "R11"; rxBusy = 1; fillCount = DEPTH - 2; tick(2);
    check("R11", "two free raises while busy", rtsN, 1'b0);
    rxBusy = 0; fillCount = DEPTH - 1; tick(2);
    // coincidence: first data bit with a slot freed and a boundary
    phase = "R7"; rxBusy = 1; tick(1);
    rxBitStb = 1; fillCount = DEPTH - 2; txBoundary = 1; tick(1);
    rxBitStb = 0; txBoundary = 0;
    check("R7", "freed slot in same cycle keeps RTS", rtsN, 1'b0);
    tick(3); rxBusy = 0; tick(2);
    // back to manual: R2 / R3
    phase = "R2"; autoFlowEn = 0; fillCount = DEPTH; ctsN = 1; txBoundary = 1; tick(3);
    check("R3", "manual ignores CTS", txPermit, 1'b1);
    check("R2", "manual ignores full buffer", rtsN, 1'b0);
    txBoundary = 0; rtsCtl = 0; tick(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule